// File: doc/BRIEF.md
# Tagged Receive Buffer with DMA Gating

This block is a small first-in first-out store that sits between a serial receiver and the system bus. Each word pushed by the receiver carries 32 data bits, five tag bits and a 2-bit byte-count code. A tag bit marks a condition the receiver found, such as end of frame (tag bit 0) or a CRC error (tag bit 1). Bits 2 to 4 are further conditions, and the buffer treats them exactly like bits 0 and 1. The read side serves a CPU or a DMA engine. The entry at the head is always visible on the read port, and a read strobe removes it.

From what it currently holds, the block derives three things. The first is a service status that means "there is something to collect". The second is a DMA request. The third is an error flag that doubles as the interrupt request. While any stored entry carries a tag, DMA requests are held off, so software has to handle frame boundaries and errors itself. Once the tagged entry has been read out, the error flag clears and DMA resumes. The head word's valid-byte code is reported alongside the data.

Top module: `rx_tag_fifo`

## Requirements
- R1: Entries are read out in the order they were written, with data on `rd_data` and tags on `rd_tag`. The head entry is visible in the cycle after it becomes head, with no read needed. While the buffer is empty, `rd_data` and `rd_tag` are zero.
- R2: After reset the buffer is empty (`empty`=1, `full`=0). With the default depth, `full` is 1 exactly when 8 entries are held, and `empty` is 1 exactly when none are held.
- R3: A write while `full` is 1 is dropped, even if a read happens in the same cycle. The stored entries and their order are unchanged.
- R4: A read while `empty` is 1 has no effect. The buffer stays empty, and a later write is still the first entry read.
- R5: `err_flag` is 1 when at least one held entry has any of its five tag bits set, and 0 otherwise. Reading out the last tagged entry clears it in the next cycle.
- R6: `svc_req` is 1 exactly when the buffer is not empty and `rx_en` is 1.
- R7: `dma_req` is 1 exactly when `svc_req` is 1 and `err_flag` is 0. Any tagged entry, including one marked end of frame (tag bit 0), blocks DMA.
- R8: `head_width` gives the byte-count code of the head entry: 00 means all four bytes are valid, 01 the low byte only, 10 the low two bytes, and 11 the low three bytes. It is 00 when the buffer is empty.
- R9: Driving `rx_en` to 0 forces `svc_req` and `dma_req` to 0 but keeps every stored entry. Reads and writes still work while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receiver enable; gates service status and DMA request |
| wr_en | input | 1 | Push one entry |
| wr_data | input | 32 | Data word to push |
| wr_tag | input | 5 | Tag bits of the pushed word (bit 0 end of frame, bit 1 CRC error) |
| wr_width | input | 2 | Byte-count code of the pushed word |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 32 | Data of the head entry |
| rd_tag | output | 5 | Tags of the head entry |
| head_width | output | 2 | Byte-count code of the head entry |
| full | output | 1 | Buffer holds its maximum number of entries |
| empty | output | 1 | Buffer holds no entries |
| svc_req | output | 1 | Receive service status |
| dma_req | output | 1 | DMA service request |
| err_flag | output | 1 | A held entry is tagged; interrupt request |

## Verification
The main sweep fills the buffer with eight words, only one of which carries a single tag bit. It walks every tag bit across every slot and then drains the buffer one read at a time. A fault that ignores one tag bit or one slot, or that clears the flag before the tagged word leaves, shows up as a wrong `err_flag` or `dma_req` at a precise read. The fill is run alternately with the receiver enabled and disabled, which separates the enable gating from the emptiness test. Separate patterns cover the byte-count code, a write into a full buffer combined with a read, a read of an empty buffer, two tagged entries that must both leave before DMA resumes, and interleaved reads and writes at partial fill.

// File: rtl/rx_tag_fifo_pkg.sv
// Package: shared widths and the stored entry layout of the tagged receive buffer.
// Assumes tag bit 0 marks end of frame and bit 1 a CRC error; all tags act alike here.
package rx_tag_fifo_pkg;
    localparam int DATA_W  = 32;
    localparam int TAG_W   = 5;
    localparam int WCODE_W = 2;

    typedef struct packed {
        logic [WCODE_W-1:0] wcode;
        logic [TAG_W-1:0]   tag;
        logic [DATA_W-1:0]  data;
    } rx_entry_t;
endpackage

// File: rtl/rx_tag_store.sv
// Module: circular storage with read/write pointers, an occupancy count and
// per-slot occupancy bits. Writes when full and reads when empty are ignored.
// Assumes DEPTH is a power of two so the pointers wrap by overflow.
module rx_tag_store
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  rx_entry_t                   wr_entry,
    input  logic                        rd_en,
    output rx_entry_t                   head_entry,
    output logic                        full,
    output logic                        empty,
    output logic [DEPTH-1:0]            occ,
    output logic [DEPTH-1:0][TAG_W-1:0] slot_tags
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    rx_entry_t          mem [DEPTH];
    logic [PTR_W-1:0]   wp;
    logic [PTR_W-1:0]   rp;
    logic [CNT_W-1:0]   cnt;
    logic               do_wr;
    logic               do_rd;

    // Accept only legal operations.
    always_comb begin
        full  = (cnt == CNT_W'(DEPTH));
        empty = (cnt == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entry storage; no reset needed, occupancy qualifies every slot.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_entry;
    end

    // Per-slot occupancy: set on write into a slot, cleared on read out of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_wr && (wp == PTR_W'(i)))      occ[i] <= 1'b1;
                else if (do_rd && (rp == PTR_W'(i))) occ[i] <= 1'b0;
            end
        end
    end

    // Expose each slot's tags for the flag reduction.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_tags[g] = mem[g].tag;
    end

    assign head_entry = mem[rp];
endmodule

// File: rtl/rx_tag_flags.sv
// Module: derives the error flag (OR of the tags of occupied slots), the service
// status and the gated DMA request. Assumes occupancy bits come from rx_tag_store.
module rx_tag_flags
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]            occ,
    input  logic [DEPTH-1:0][TAG_W-1:0] slot_tags,
    input  logic                        rx_en,
    input  logic                        empty,
    output logic                        err_flag,
    output logic                        svc_req,
    output logic                        dma_req
);
    logic [DEPTH-1:0] slot_hit;

    // A slot contributes only while it holds a live entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign slot_hit[g] = occ[g] && (|slot_tags[g]);
    end

    // Combine into the three status outputs.
    always_comb begin
        err_flag = |slot_hit;
        svc_req  = rx_en && !empty;
        dma_req  = svc_req && !err_flag;
    end
endmodule

// File: rtl/rx_tag_head.sv
// Module: presents the head entry on the read port, zeroing it while empty.
// Assumes head_entry may hold stale content when the buffer is empty.
module rx_tag_head
    import rx_tag_fifo_pkg::*;
(
    input  rx_entry_t           head_entry,
    input  logic                empty,
    output logic [DATA_W-1:0]   rd_data,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [WCODE_W-1:0]  head_width
);
    // Mask the head fields when nothing is held.
    always_comb begin
        if (empty) begin
            rd_data    = '0;
            rd_tag     = '0;
            head_width = '0;
        end else begin
            rd_data    = head_entry.data;
            rd_tag     = head_entry.tag;
            head_width = head_entry.wcode;
        end
    end
endmodule

// File: rtl/rx_tag_fifo.sv
// Module: tagged receive buffer top. Stores data, tag and byte-count code per word,
// shows the head entry, and gates DMA requests while any held entry is tagged.
// Assumes a single clock and a power-of-two DEPTH.
module rx_tag_fifo
    import rx_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [WCODE_W-1:0]  wr_width,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [WCODE_W-1:0]  head_width,
    output logic                full,
    output logic                empty,
    output logic                svc_req,
    output logic                dma_req,
    output logic                err_flag
);
    rx_entry_t                   wr_entry;
    rx_entry_t                   head_entry;
    logic [DEPTH-1:0]            occ;
    logic [DEPTH-1:0][TAG_W-1:0] slot_tags;

    // Pack the incoming word.
    always_comb begin
        wr_entry.data  = wr_data;
        wr_entry.tag   = wr_tag;
        wr_entry.wcode = wr_width;
    end

    rx_tag_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_entry   (wr_entry),
        .rd_en      (rd_en),
        .head_entry (head_entry),
        .full       (full),
        .empty      (empty),
        .occ        (occ),
        .slot_tags  (slot_tags)
    );

    rx_tag_flags #(.DEPTH(DEPTH)) u_flags (
        .occ        (occ),
        .slot_tags  (slot_tags),
        .rx_en      (rx_en),
        .empty      (empty),
        .err_flag   (err_flag),
        .svc_req    (svc_req),
        .dma_req    (dma_req)
    );

    rx_tag_head u_head (
        .head_entry (head_entry),
        .empty      (empty),
        .rd_data    (rd_data),
        .rd_tag     (rd_tag),
        .head_width (head_width)
    );
endmodule

// File: rtl/rx_tag_fifo_chk.sv
// Module: property checker for rx_tag_fifo, attached by bind below.
// Assumes it observes the top-level ports only.
module rx_tag_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [4:0]  rd_tag,
    input logic [1:0]  head_width,
    input logic        full,
    input logic        empty,
    input logic        svc_req,
    input logic        dma_req,
    input logic        err_flag
);
    // R2: never both full and empty.
    p_not_full_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3: a write into a full buffer without a read leaves it full.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    // R4: reading an empty buffer without a write leaves it empty.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);

    // R5: an empty buffer carries no error.
    p_err_needs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !err_flag);

    // R6: no service status while the buffer is empty.
    p_svc_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> !empty);

    // R7: DMA request only with service status and no error.
    p_dma_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (svc_req && !err_flag));

    // R8: head fields are zero while empty.
    p_head_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (head_width == 2'b00 && rd_data == 32'h0 && rd_tag == 5'h0));

    // R9: with the receiver disabled and no traffic, the head is kept.
    p_disable_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !wr_en && !rd_en) |=> ($stable(rd_data) && $stable(empty)));

    // R9: disabled receiver requests no service.
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (!svc_req && !dma_req));
endmodule

bind rx_tag_fifo rx_tag_fifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_tag     (rd_tag),
    .head_width (head_width),
    .full       (full),
    .empty      (empty),
    .svc_req    (svc_req),
    .dma_req    (dma_req),
    .err_flag   (err_flag)
);

// File: tb/rx_tag_fifo_tb.sv
`timescale 1ns/1ps
// Bench: sweeps tag bit and slot position, byte-count codes and edge operations,
// comparing every output against an arithmetic reference queue.
module rx_tag_fifo_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [4:0]  wr_tag;
    logic [1:0]  wr_width;
    logic        rd_en;
    logic [31:0] rd_data;
    logic [4:0]  rd_tag;
    logic [1:0]  head_width;
    logic        full;
    logic        empty;
    logic        svc_req;
    logic        dma_req;
    logic        err_flag;

    int nchk = 0;
    int nerr = 0;

    // reference queue
    logic [31:0] q_data [DEPTH];
    logic [4:0]  q_tag  [DEPTH];
    logic [1:0]  q_wc   [DEPTH];
    int          q_rd = 0;
    int          q_cnt = 0;

    always #5 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_en(wr_en),
        .wr_data(wr_data), .wr_tag(wr_tag), .wr_width(wr_width), .rd_en(rd_en),
        .rd_data(rd_data), .rd_tag(rd_tag), .head_width(head_width),
        .full(full), .empty(empty), .svc_req(svc_req), .dma_req(dma_req),
        .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_all();
        logic e_err;
        int   hd;
        e_err = 1'b0;
        for (int i = 0; i < q_cnt; i++) e_err |= (|q_tag[(q_rd + i) % DEPTH]);
        hd = q_rd;
        chk("R2", "empty", empty, q_cnt == 0);
        chk("R2", "full", full, q_cnt == DEPTH);
        chk("R1", "rd_data", rd_data, (q_cnt == 0) ? 32'h0 : q_data[hd]);
        chk("R1", "rd_tag", rd_tag, (q_cnt == 0) ? 5'h0 : q_tag[hd]);
        chk("R8", "head_width", head_width, (q_cnt == 0) ? 2'b00 : q_wc[hd]);
        chk("R5", "err_flag", err_flag, e_err);
        chk("R6", "svc_req", svc_req, rx_en && (q_cnt != 0));
        chk("R7", "dma_req", dma_req, rx_en && (q_cnt != 0) && !e_err);
    endtask

    // One clock of traffic, then reference update and full comparison.
    task automatic step(input logic w, input logic [31:0] d, input logic [4:0] t,
                        input logic [1:0] wc, input logic r);
        bit was_full;
        wr_en = w; wr_data = d; wr_tag = t; wr_width = wc; rd_en = r;
        @(posedge clk);
        was_full = (q_cnt == DEPTH);
        if (r && q_cnt != 0) begin
            q_rd = (q_rd + 1) % DEPTH;
            q_cnt--;
        end
        if (w && !was_full) begin
            q_data[(q_rd + q_cnt) % DEPTH] = d;
            q_tag[(q_rd + q_cnt) % DEPTH]  = t;
            q_wc[(q_rd + q_cnt) % DEPTH]   = wc;
            q_cnt++;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_all();
    endtask

    task automatic drain();
        while (q_cnt != 0) step(1'b0, 32'h0, 5'h0, 2'b00, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; wr_tag = '0; wr_width = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all();                                  // R2 reset state

        // R4: read from empty is ignored; next write is first out
        step(1'b0, 32'h0, 5'h0, 2'b00, 1'b1);
        chk("R4", "empty after empty read", empty, 1'b1);
        step(1'b1, 32'hA5A5_0001, 5'h0, 2'b01, 1'b0);
        chk("R4", "first word after empty read", rd_data, 32'hA5A5_0001);
        drain();

        // R8/R1/R3: fill with each byte-count code, then write while full
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 32'h1000_0000 + i * 32'h0101, 5'h0, 2'(i % 4), 1'b0);
        step(1'b1, 32'hDEAD_BEEF, 5'h1F, 2'b11, 1'b0);
        chk("R3", "full after dropped write", full, 1'b1);
        chk("R3", "no error from dropped tagged write", err_flag, 1'b0);
        step(1'b1, 32'hDEAD_BEE0, 5'h1F, 2'b11, 1'b1);
        chk("R3", "write with read while full dropped", full, 1'b0);
        drain();
        chk("R3", "dropped words never read", empty, 1'b1);

        // R5/R7: walk each tag bit through each slot; fill with receiver on/off
        for (int b = 0; b < 5; b++) begin
            for (int k = 0; k < DEPTH; k++) begin
                rx_en = k[0];
                for (int i = 0; i < DEPTH; i++)
                    step(1'b1, {b[7:0], k[7:0], 8'h5C, i[7:0]},
                         (i == k) ? 5'(1 << b) : 5'h0, 2'((i + b) % 4), 1'b0);
                rx_en = 1'b1;
                #1;
                check_all();
                drain();
            end
        end

        // R5: two tagged entries; DMA resumes only after both leave
        for (int i = 0; i < 6; i++)
            step(1'b1, 32'hC0DE_0000 + i, (i == 1 || i == 4) ? 5'h1F : 5'h0, 2'b10, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 32'h0, 5'h0, 2'b00, 1'b1);
            chk("R5", "err after read", err_flag, (i < 4) ? 1'b1 : 1'b0);
        end

        // R9: disabled receiver keeps entries and still accepts traffic
        step(1'b1, 32'h9999_0001, 5'h0, 2'b00, 1'b0);
        step(1'b1, 32'h9999_0002, 5'h2, 2'b01, 1'b0);
        rx_en = 1'b0;
        #1;
        check_all();
        repeat (4) step(1'b0, 32'h0, 5'h0, 2'b00, 1'b0);
        chk("R9", "head kept while disabled", rd_data, 32'h9999_0001);
        chk("R9", "svc off while disabled", svc_req, 1'b0);
        step(1'b1, 32'h9999_0003, 5'h0, 2'b11, 1'b1);
        chk("R9", "read while disabled", rd_data, 32'h9999_0002);
        rx_en = 1'b1;
        #1;
        check_all();
        drain();

        // R1: interleaved reads and writes at partial fill
        for (int i = 0; i < 3; i++) step(1'b1, 32'h7700_0000 + i, 5'h0, 2'b00, 1'b0);
        for (int i = 0; i < 20; i++)
            step(1'b1, 32'h7711_0000 + i, (i % 7 == 3) ? 5'h8 : 5'h0, 2'(i % 4), 1'b1);
        drain();

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule